// File: doc/BRIEF.md
# Set-Clear GPIO Port Controller

This block is a 32-pin general-purpose I/O port reached through a plain memory-mapped register bus with separate read and write strobes, an address and a data word. Software never rewrites a whole output word. It writes a mask of ones to a set register or to a clear register, and only the marked pins change. Each such write also makes the marked pins drive, so no separate direction register is needed. A third write location, the float register, stops the marked pins from driving and returns them to input mode.

The input side is off after reset. Pin levels pass through a two-flop synchronizer, but a pin-state read returns zero until software has written the pin-state location once, whatever data that write carries. After that single write the input path stays open until the next reset. The block drives per-pin output data and output-enable signals for the pad ring. Reads are combinational: a read in the same cycle as a write returns the state from before that write.

Top module: `sc_gpio_port`

## Requirements
- R1: After reset every output-enable bit is 0, every output-data bit is 0 and the input path is closed.
- R2: A write to offset 0x108 sets to 1 each output-data bit whose data bit is 1 and leaves the others unchanged; a read of 0x108 returns the output-data word, with pin n at bit n.
- R3: A write to offset 0x10C clears to 0 each output-data bit whose data bit is 1 and leaves the others unchanged.
- R4: A write to 0x108 or to 0x10C sets the output-enable bit of each pin whose data bit is 1; pins with a 0 data bit keep their enable.
- R5: A write to offset 0x100 clears the output-enable bit of each pin whose data bit is 1 and leaves output data unchanged; a read of 0x100 returns the output-enable word.
- R6: Until offset 0x110 has been written at least once after reset, a read of 0x110 returns zero for every pin.
- R7: Once 0x110 has been written with any data, a read of 0x110 returns the level that pin_in had at the rising edge two edges before the read cycle (two-flop synchronizer).
- R8: A read of any other offset returns zero, and a write to any other offset changes neither output data nor output enable.
- R9: A read that falls in the same cycle as a write returns the state from before the write; bus_rdata is zero when bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output data toward the pads |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The enabling write to the pin-state location and a read of that same location can fall in one cycle. The bench raises both strobes at 0x110 together while pin_in carries a nonzero pattern. The read must return zero, and from the next cycle on the synchronized pin levels must appear. A set write that is read back at the same offset in the same cycle is checked the same way: the read must return the output word from before the write, and the reference model judges every cycle's outputs against its own state.

// File: rtl/sc_gpio_port.sv
module sc_gpio_port #(
  parameter int PINS = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);

  localparam logic [AW-1:0] OFS_FLOAT = AW'('h100);
  localparam logic [AW-1:0] OFS_SET   = AW'('h108);
  localparam logic [AW-1:0] OFS_CLR   = AW'('h10C);
  localparam logic [AW-1:0] OFS_PINS  = AW'('h110);

  logic [PINS-1:0] drv_q, oe_q, meta_q, sync_q;
  logic            in_open_q;

  wire hit_float = bus_addr == OFS_FLOAT;
  wire hit_set   = bus_addr == OFS_SET;
  wire hit_clr   = bus_addr == OFS_CLR;
  wire hit_pins  = bus_addr == OFS_PINS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q     <= '0;
      oe_q      <= '0;
      in_open_q <= 1'b0;
    end else if (bus_wr) begin
      if (hit_set) begin
        drv_q <= drv_q | bus_wdata;
        oe_q  <= oe_q | bus_wdata;
      end
      if (hit_clr) begin
        drv_q <= drv_q & ~bus_wdata;
        oe_q  <= oe_q | bus_wdata;
      end
      if (hit_float) oe_q <= oe_q & ~bus_wdata;
      if (hit_pins)  in_open_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_float)     bus_rdata = oe_q;
      else if (hit_set)  bus_rdata = drv_q;
      else if (hit_pins) bus_rdata = in_open_q ? sync_q : '0;
    end
  end

  assign pin_out = drv_q;
  assign pin_oe  = oe_q;

  a_r4_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (hit_set || hit_clr)) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_clr) |=> ((pin_out & $past(bus_wdata)) == '0));

  a_r5_float_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_float) |=> ((pin_oe & $past(bus_wdata)) == '0) && $stable(pin_out));

  a_r6_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_open_q && bus_rd && hit_pins) |-> (bus_rdata == '0));

  a_r8_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(hit_float || hit_set || hit_clr || hit_pins)) |=> $stable(pin_out) && $stable(pin_oe));

endmodule

// File: tb/tb_sc_gpio_port.sv
`timescale 1ns/1ps
module tb_sc_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;

  int checks = 0, fails = 0;
  logic [31:0] m_out, m_oe;
  bit          m_en;
  logic [31:0] hist[$];

  always #2.5 clk = ~clk;

  sc_gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h100: return m_oe;
      12'h108: return m_out;
      12'h110: return m_en ? hist[1] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [11:0] a, bit wr);
    if (wr) return "R9";
    case (a)
      12'h100: return "R5";
      12'h108: return "R2";
      12'h110: return m_en ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic cyc(bit wr, bit rd, logic [11:0] a, logic [31:0] d, logic [31:0] p);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; pin_in = p;
    #1;
    if (rd) check(read_tag(a, wr), bus_rdata, model_read(a));
    else    check("R9", bus_rdata, 32'h0);
    check("R2", pin_out, m_out);
    check("R4", pin_oe, m_oe);
    @(posedge clk);
    if (wr) begin
      case (a)
        12'h100: m_oe = m_oe & ~d;
        12'h108: begin m_out = m_out | d; m_oe = m_oe | d; end
        12'h10C: begin m_out = m_out & ~d; m_oe = m_oe | d; end
        12'h110: m_en = 1'b1;
        default: ;
      endcase
    end
    hist.push_front(p);
    void'(hist.pop_back());
  endtask

  initial begin
    #900000;
    fails++; checks++;
    $display("FAIL watchdog expected=finish actual=timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    m_out = '0; m_oe = '0; m_en = 1'b0; hist = '{32'h0, 32'h0};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1", pin_out, 32'h0);
    check("R1", pin_oe, 32'h0);
    // R6: input closed despite activity
    cyc(0, 1, 12'h110, 0, 32'hDEADBEEF);
    cyc(0, 1, 12'h110, 0, 32'hFFFFFFFF);
    cyc(0, 1, 12'h110, 0, 32'h12345678);
    // R2, R4 set; R3 clear
    cyc(1, 0, 12'h108, 32'h0000_00FF, 0);
    cyc(0, 1, 12'h108, 0, 0);
    cyc(1, 0, 12'h10C, 32'h0000_F00F, 0);
    cyc(0, 1, 12'h108, 0, 0);
    cyc(0, 1, 12'h100, 0, 0);
    // R5 float
    cyc(1, 0, 12'h100, 32'h0000_0003, 0);
    cyc(0, 1, 12'h100, 0, 0);
    // R8 undefined offsets
    cyc(1, 1, 12'h104, 32'hFFFFFFFF, 0);
    cyc(1, 0, 12'h200, 32'hFFFFFFFF, 0);
    cyc(0, 1, 12'h10C, 0, 0);
    cyc(0, 1, 12'h000, 0, 0);
    // R9 set write and readback in one cycle
    cyc(1, 1, 12'h108, 32'hA5A5_0000, 32'h0F0F0F0F);
    // R6/R7 enabling write and pin read in one cycle
    cyc(1, 1, 12'h110, 32'h0, 32'h0F0F0F0F);
    cyc(0, 1, 12'h110, 0, 32'hAAAA5555);
    cyc(0, 1, 12'h110, 0, 32'h80000001);
    cyc(0, 1, 12'h110, 0, 32'h0);
    cyc(0, 1, 12'h110, 0, 32'h0);
    // mixed traffic for R2 R3 R4 R5 R7 R8
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1: a = 12'h108;
        3'd2, 3'd3: a = 12'h10C;
        3'd4:       a = 12'h100;
        3'd5:       a = 12'h110;
        3'd6:       a = 12'h114;
        default:    a = 12'h0FC;
      endcase
      cyc(lfsr[3], lfsr[4], a, lfsr ^ 32'h5A5A_C3C3, {lfsr[15:0], lfsr[31:16]});
    end
    // R5 float all pins, R1 reset again
    cyc(1, 0, 12'h100, 32'hFFFFFFFF, 0);
    cyc(0, 1, 12'h100, 0, 0);
    @(negedge clk); rst_n = 1'b0; bus_wr = 0; bus_rd = 0;
    m_out = '0; m_oe = '0; m_en = 1'b0; hist = '{32'h0, 32'h0};
    @(negedge clk); rst_n = 1'b1;
    check("R1", pin_out, 32'h0);
    cyc(0, 1, 12'h110, 0, 32'hFFFFFFFF);
    cyc(0, 1, 12'h110, 0, 32'hFFFFFFFF);
    cyc(0, 1, 12'h110, 0, 32'hFFFFFFFF);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule